// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `OP_W` bits (32 by default) and gives a `2*OP_W`-bit result. It uses a single `OP_W`-bit adder over `OP_W` clock cycles. A start request latches the multiplicand into its own register. The same request loads the multiplier operand into the lower half of a double-width product register and clears the upper half.

Each cycle does one iteration. The iteration looks at bit 0 of the product register and adds the multiplicand into the upper half only when that bit is set. It then shifts the whole register one place to the right. The adder's carry enters at the top bit, so the result is exact for every operand pair. The low half is used up as it shifts, and the partial product grows into the space it leaves behind.

The adder carry from the most recent iteration is driven out as an overflow flag. A completion flag goes high after the last iteration. It stays high, with the result held, until the next accepted start. A start request that arrives during a run is ignored. All state is clocked by one common clock and has a synchronous active-high reset.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `done` and `ovf` are low and `product` is all zeros.
- R2: A `start` high at a rising edge while no run is in progress loads the operands. In the cycle after that edge, `product` equals `{OP_W zeros, mplier_in}` and `done` and `ovf` are low.
- R3: When `done` goes high, `product` equals the exact unsigned product `mcand_in * mplier_in` of the operands sampled at the accepted start.
- R4: `done` stays low for the first `OP_W-1` rising edges after the accepted start edge. It goes high at exactly the `OP_W`-th such edge.
- R5: While `done` is high and `start` is low, `done`, `product` and `ovf` keep their values.
- R6: A `start` high during a run has no effect. The run finishes at the original time with the original operands' product.
- R7: `ovf` is the adder carry of the most recent iteration. It is cleared at an accepted start. When `done` is high it equals `product` bit `2*OP_W-1`.
- R8: A synchronous reset during a run stops it. `done` stays low and `product` is zero until a new start is accepted.
- R9: After k iterations (1 ≤ k ≤ `OP_W`), `product` equals `(mcand * (mplier mod 2^k)) * 2^(OP_W-k) + (mplier >> k)`. This means an iteration whose tested bit is 0 adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted when no run is in progress |
| mcand_in | input | OP_W | Multiplicand operand |
| mplier_in | input | OP_W | Multiplier operand |
| product | output | 2*OP_W | Contents of the product register |
| done | output | 1 | High from the end of a run until the next accepted start |
| ovf | output | 1 | Adder carry of the most recent iteration |

## Verification
A 4-bit instance is driven through all 256 operand pairs. After every iteration, the product register is compared with the arithmetic partial-product formula. This separates a missing or extra add, a wrong shift direction and a lost carry, step by step. The 32-bit instance runs corner operands: all zeros, all ones, single-bit operands and mixed patterns. These exercise the carry into the top bit, the overflow flag and the exact completion cycle. Dedicated runs inject a start mid-run, hold the result idle, and reset partway through a run.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sam_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } sam_ctl_t;

    function automatic int unsigned iter_cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
    import sam_pkg::*;
#(
    parameter int unsigned OP_W = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output sam_ctl_t ctl,
    output logic     running,
    output logic     done
);
    localparam int unsigned     CNT_W = iter_cnt_width(OP_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

    sam_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl.step = (state_q == ST_RUN);
        ctl.load = start && (state_q != ST_RUN);
        running  = ctl.step;
        done     = (state_q == ST_DONE);
    end

endmodule

// File: rtl/sam_adder.sv
module sam_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         en,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] addend;
    logic [W:0]   total;

    always_comb begin
        addend      = en ? b : '0;
        total       = {1'b0, a} + {1'b0, addend};
        {cout, sum} = total;
    end

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
    import sam_pkg::*;
#(
    parameter int unsigned OP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  sam_ctl_t          ctl,
    input  logic [OP_W-1:0]   mcand_in,
    input  logic [OP_W-1:0]   mplier_in,
    output logic [2*OP_W-1:0] product,
    output logic              ovf
);
    localparam int unsigned P_W = 2 * OP_W;

    logic [OP_W-1:0] mcand_q;
    logic [P_W-1:0]  prod_q;
    logic            ovf_q;
    logic [OP_W-1:0] sum;
    logic            cout;

    sam_adder #(.W(OP_W)) u_adder (
        .a    (prod_q[P_W-1:OP_W]),
        .b    (mcand_q),
        .en   (prod_q[0]),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
            ovf_q   <= 1'b0;
        end else if (ctl.load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{OP_W{1'b0}}, mplier_in};
            ovf_q   <= 1'b0;
        end else if (ctl.step) begin
            prod_q  <= {cout, sum, prod_q[OP_W-1:1]};
            ovf_q   <= cout;
        end
    end

    assign product = prod_q;
    assign ovf     = ovf_q;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import sam_pkg::*;
#(
    parameter int unsigned OP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand_in,
    input  logic [OP_W-1:0]   mplier_in,
    output logic [2*OP_W-1:0] product,
    output logic              done,
    output logic              ovf
);
    sam_ctl_t ctl;
    logic     running;

    sam_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ctl     (ctl),
        .running (running),
        .done    (done)
    );

    sam_datapath #(.OP_W(OP_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .product   (product),
        .ovf       (ovf)
    );

endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int unsigned OP_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              running,
    input logic              done,
    input logic              ovf,
    input logic [OP_W-1:0]   mplier_in,
    input logic [2*OP_W-1:0] product
);
    localparam int unsigned CW = $clog2(OP_W) + 2;

    // cycles elapsed since the accepted start edge
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (start && !running) begin
            run_cnt <= '0;
        end else if (running) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !running) |=>
            (product == {{OP_W{1'b0}}, $past(mplier_in)}) && !done && !ovf);

    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (run_cnt == CW'(OP_W)));

    p_busy_not_done_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> !done);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done && $stable(product) && $stable(ovf));

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (running && start && (run_cnt != CW'(OP_W - 1))) |=> running && !done);

    p_ovf_msb_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (ovf == product[2*OP_W-1]));

endmodule

bind shift_add_mul shift_add_mul_chk #(.OP_W(OP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .running   (running),
    .done      (done),
    .ovf       (ovf),
    .mplier_in (mplier_in),
    .product   (product)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    // 32-bit instance
    logic        b_start = 1'b0;
    logic [31:0] b_mcand = '0;
    logic [31:0] b_mplier = '0;
    logic [63:0] b_prod;
    logic        b_done, b_ovf;

    shift_add_mul #(.OP_W(32)) u_shift_add_mul (
        .clk(clk), .rst(rst), .start(b_start),
        .mcand_in(b_mcand), .mplier_in(b_mplier),
        .product(b_prod), .done(b_done), .ovf(b_ovf)
    );

    // 4-bit instance for the exhaustive sweep
    logic       s_start = 1'b0;
    logic [3:0] s_mcand = '0;
    logic [3:0] s_mplier = '0;
    logic [7:0] s_prod;
    logic       s_done, s_ovf;

    shift_add_mul #(.OP_W(4)) u_shift_add_mul_w4 (
        .clk(clk), .rst(rst), .start(s_start),
        .mcand_in(s_mcand), .mplier_in(s_mplier),
        .product(s_prod), .done(s_done), .ovf(s_ovf)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    task automatic run_small(input logic [3:0] a, input logic [3:0] b);
        int unsigned exp;
        @(negedge clk);
        s_start = 1'b1; s_mcand = a; s_mplier = b;
        @(negedge clk);
        s_start = 1'b0;
        chk(s_prod == {4'h0, b} && !s_done && !s_ovf, "R2 small load",
            64'(s_prod), 64'({4'h0, b}));
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            exp = ((32'(a) * (32'(b) & ((32'd1 << k) - 1))) << (4 - k)) + (32'(b) >> k);
            chk(s_prod == exp[7:0], "R9 small partial product", 64'(s_prod), 64'(exp[7:0]));
            chk(s_done == (k == 4), "R4 small done timing", 64'(s_done), 64'(k == 4));
        end
        chk(s_prod == 8'(a * b), "R3 small result", 64'(s_prod), 64'(32'(a) * 32'(b)));
        chk(s_ovf == s_prod[7], "R7 small ovf", 64'(s_ovf), 64'(s_prod[7]));
    endtask

    task automatic run_big(input logic [31:0] a, input logic [31:0] b, input bit inject);
        logic [63:0] exp;
        bit early;
        early = 1'b0;
        exp = 64'(a) * 64'(b);
        @(negedge clk);
        b_start = 1'b1; b_mcand = a; b_mplier = b;
        @(negedge clk);
        b_start = 1'b0;
        chk(b_prod == {32'h0, b} && !b_done && !b_ovf, "R2 load", b_prod, {32'h0, b});
        for (int k = 1; k <= 32; k++) begin
            if (inject && k == 10) begin
                b_start = 1'b1; b_mcand = ~a; b_mplier = ~b;
            end
            @(negedge clk);
            b_start = 1'b0;
            if (k < 32 && b_done) early = 1'b1;
        end
        chk(!early, inject ? "R6 done early after injected start" : "R4 done early",
            64'(early), 64'(0));
        chk(b_done, "R4 done at cycle OP_W", 64'(b_done), 64'(1));
        chk(b_prod == exp, inject ? "R6 result with injected start" : "R3 result", b_prod, exp);
        chk(b_ovf == exp[63], "R7 ovf equals carry into msb", 64'(b_ovf), 64'(exp[63]));
        repeat (3) @(negedge clk);
        chk(b_done && b_prod == exp && b_ovf == exp[63], "R5 result held",
            b_prod, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(b_prod == 64'h0 && !b_done && !b_ovf, "R1 reset state", b_prod, 64'h0);
        chk(s_prod == 8'h0 && !s_done && !s_ovf, "R1 small reset state", 64'(s_prod), 64'h0);

        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_small(4'(a), 4'(b));
            end
        end

        run_big(32'h0000_0000, 32'h0000_0000, 1'b0);
        run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_big(32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
        run_big(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        run_big(32'h8000_0000, 32'h0000_0002, 1'b0);
        run_big(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
        run_big(32'hDEAD_BEEF, 32'h8000_0001, 1'b0);
        run_big(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1);

        // R8: reset partway through a run
        @(negedge clk);
        b_start = 1'b1; b_mcand = 32'hCAFE_F00D; b_mplier = 32'h0BAD_BEEF;
        @(negedge clk);
        b_start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!b_done && b_prod == 64'h0, "R8 reset mid-run clears", b_prod, 64'h0);
        repeat (40) @(negedge clk);
        chk(!b_done && b_prod == 64'h0, "R8 no resumption after reset", b_prod, 64'h0);
        run_big(32'hCAFE_F00D, 32'h0BAD_BEEF, 1'b0);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule